// File: doc/BRIEF.md
# Interval Timer with Shared Interrupt

This peripheral holds one or two independent 32-bit interval counters behind a small word-addressed register port. The channel count is set by a parameter. Software writes a start value into a channel's load word. It then writes the channel's control word with the run bit set. That write copies the load value into the live counter and starts it. The counter steps by one every clock, either upward or downward. It expires when it reaches its terminal value: zero when counting down, all ones when counting up. On expiry it sets a sticky interrupt flag. With auto-restart selected it then reloads and carries on; otherwise it halts on the terminal value.

All channels drive one interrupt line. Each channel contributes only while its interrupt-enable bit is set. Software acknowledges an expiry by writing a one to the flag bit. Several control bits exist only as storage, for software that expects them, and have no effect on counting.

Each channel owns four consecutive words. The word address splits into a channel index (upper bits) and a register selector (low two bits). Every access moves a full 32-bit word, and reads are combinational from the address.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register of every channel reads zero and `timer_irq` is low.
- R2: A control write with bit 7 (run) set copies the channel's load word (selector 1) into its counter (selector 2) at that clock edge and starts counting on the next edge.
- R3: With control bit 1 set (downward), a running counter decrements each clock; when it is zero it expires on the next edge, so a counter started at L expires L+1 clocks after the starting write.
- R4: With control bit 1 clear (upward), a running counter increments each clock; when it is all ones it expires on the next edge, so a counter started at L expires (2^32-1-L)+1 clocks after the starting write.
- R5: On expiry with control bit 4 (auto-restart) set, the counter is reloaded from the load word and keeps running.
- R6: On expiry with bit 4 clear, the channel stops and its counter holds the terminal value until a new control write with bit 7 set.
- R7: `timer_irq` is high exactly when some present channel has both control bit 8 (flag) and control bit 6 (interrupt enable) set.
- R8: Expiry sets control bit 8. A control write with bit 8 set clears it, and a write with bit 8 clear leaves it unchanged. An expiry on the same edge as a clearing write leaves it set.
- R9: The channel index is the word address above bit 1, and selector 3 reads zero. Addresses of a channel beyond the configured count read zero, and writes to them have no effect.
- R10: Control bits 0–7, 9 and 10 are stored as written and read back; control-word bits 31–11 read zero.
- R11: Writes to the counter word (selector 2) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address: channel index above bit 1, register selector in bits 1:0 |
| bus_wr | input | 1 | Write strobe for a full 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| timer_irq | output | 1 | Shared interrupt: OR of flag AND enable over present channels |

## Verification
Two functions can land on the same clock edge: a channel's expiry and a software write to its control word. The bench counts cycles from a starting write to one auto-restarting downward channel. It times a flag-clearing write so that it takes effect on the edge that expires the channel. It then reads the control word and expects the flag still set, with the counter back at the load value. A second clearing write, placed on an ordinary counting edge, must clear the flag. That pair separates "set wins" from "clear wins".

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CTL_W    = 11;
    // control-word bit positions that the counting logic decodes
    localparam int unsigned CTL_DOWN = 1;
    localparam int unsigned CTL_AUTO = 4;
    localparam int unsigned CTL_IE   = 6;
    localparam int unsigned CTL_RUN  = 7;
    localparam int unsigned CTL_FLAG = 8;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LOAD  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CTL_W-1:0]  ctrl;
        logic [WORD_W-1:0] load;
        logic [WORD_W-1:0] cnt;
        logic              run;
    } chan_state_t;
endpackage

// File: rtl/itmr_channel.sv
module itmr_channel
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_load,
    input  logic [WORD_W-1:0] wdata,
    output logic [CTL_W-1:0]  ctrl_o,
    output logic [WORD_W-1:0] load_o,
    output logic [WORD_W-1:0] cnt_o,
    output logic              irq_o
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(1);

    chan_state_t st_d, st_q;
    logic        down, at_end, expire, restart;

    always_comb begin
        st_d    = st_q;
        down    = st_q.ctrl[CTL_DOWN];
        at_end  = down ? (st_q.cnt == '0) : (st_q.cnt == '1);
        expire  = st_q.run && at_end;
        restart = wr_ctrl && wdata[CTL_RUN];

        if (st_q.run) begin
            if (expire) begin
                if (st_q.ctrl[CTL_AUTO]) st_d.cnt = st_q.load;
                else                     st_d.run = 1'b0;
            end else begin
                st_d.cnt = down ? st_q.cnt - STEP : st_q.cnt + STEP;
            end
        end

        if (wr_load) st_d.load = wdata;

        if (wr_ctrl) begin
            st_d.ctrl           = wdata[CTL_W-1:0];
            st_d.ctrl[CTL_FLAG] = st_q.ctrl[CTL_FLAG] & ~wdata[CTL_FLAG];
        end
        if (restart) begin
            st_d.cnt = st_q.load;
            st_d.run = 1'b1;
        end

        if (expire) st_d.ctrl[CTL_FLAG] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign load_o = st_q.load;
    assign cnt_o  = st_q.cnt;
    assign irq_o  = st_q.ctrl[CTL_FLAG] & st_q.ctrl[CTL_IE];

    p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_o == $past(load_o)) && st_q.run);

    p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run && down && (cnt_o != '0) && !wr_ctrl |=> cnt_o == $past(cnt_o) - STEP);

    p_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run && !down && (cnt_o != '1) && !wr_ctrl |=> cnt_o == $past(cnt_o) + STEP);

    p_auto_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire && ctrl_o[CTL_AUTO] && !restart |=> st_q.run && (cnt_o == $past(load_o)));

    p_oneshot_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !ctrl_o[CTL_AUTO] && !restart |=> !st_q.run && $stable(cnt_o));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[CTL_FLAG] && !(wr_ctrl && wdata[CTL_FLAG]) |=> ctrl_o[CTL_FLAG]);

    p_expiry_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ctrl_o[CTL_FLAG]);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import itmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              timer_irq
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  ch_idx;
    reg_sel_e          sel;
    logic [CTL_W-1:0]  ch_ctrl [NUM_CH];
    logic [WORD_W-1:0] ch_load [NUM_CH];
    logic [WORD_W-1:0] ch_cnt  [NUM_CH];
    logic [NUM_CH-1:0] ch_irq;
    logic              present;

    assign ch_idx = bus_addr[ADDR_W-1:2];
    assign sel    = reg_sel_e'(bus_addr[1:0]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = bus_wr && (ch_idx == IDX_W'(g));

        itmr_channel u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (hit && (sel == SEL_CTRL)),
            .wr_load (hit && (sel == SEL_LOAD)),
            .wdata   (bus_wdata),
            .ctrl_o  (ch_ctrl[g]),
            .load_o  (ch_load[g]),
            .cnt_o   (ch_cnt[g]),
            .irq_o   (ch_irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        present   = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == IDX_W'(i)) begin
                present = 1'b1;
                case (sel)
                    SEL_CTRL:  bus_rdata = {{(WORD_W-CTL_W){1'b0}}, ch_ctrl[i]};
                    SEL_LOAD:  bus_rdata = ch_load[i];
                    SEL_COUNT: bus_rdata = ch_cnt[i];
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

    assign timer_irq = |ch_irq;

    p_irq_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq && !bus_wr |=> timer_irq);

    p_absent_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !present || (sel == SEL_SPARE) |-> bus_rdata == '0);
endmodule

// File: tb/test_dual_interval_timer.sv
module test_dual_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_dual, rdata_one;
    logic        irq_dual, irq_one;
    int          n_total = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    dual_interval_timer #(.NUM_CH(2), .ADDR_W(3)) i_dual_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_dual), .timer_irq(irq_dual));

    dual_interval_timer #(.NUM_CH(1), .ADDR_W(3)) i_single_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_one), .timer_irq(irq_one));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // caller stands at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = rdata_dual;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 register after reset", v, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq_dual}, 32'h0);
    endtask

    task automatic t_down_restart();
        logic [31:0] v;
        wr(3'd1, 32'd3);
        wr(3'd0, 32'h0000_00D2);      // run, ie, auto-restart, down
        rd(3'd2, v); chk("R2 counter loaded", v, 32'd3);
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            rd(3'd2, v); chk("R3 decrement", v, 32'(3 - i));
        end
        chk("R7 irq before expiry", {31'b0, irq_dual}, 32'h0);
        @(negedge clk);
        rd(3'd0, v); chk("R3 flag after L+1 clocks", v, 32'h0000_01D2);
        rd(3'd2, v); chk("R5 reloaded", v, 32'd3);
        chk("R7 irq raised", {31'b0, irq_dual}, 32'h1);
        repeat (3) @(negedge clk);
        rd(3'd2, v); chk("R5 still running", v, 32'd0);
        wr(3'd0, 32'h0000_0152);      // clearing write on the expiry edge
        rd(3'd0, v); chk("R8 expiry beats clear", v, 32'h0000_0152);
        wr(3'd0, 32'h0000_0152);      // clearing write on a plain edge
        rd(3'd0, v); chk("R8 clear takes effect", v, 32'h0000_0052);
        chk("R7 irq dropped", {31'b0, irq_dual}, 32'h0);
        wr(3'd0, 32'h0000_0002);      // down, no restart, no ie
        repeat (8) @(negedge clk);
        rd(3'd2, v); chk("R6 halted at zero", v, 32'd0);
        rd(3'd0, v); chk("R6 flag on halt", v, 32'h0000_0102);
        chk("R7 flag without enable", {31'b0, irq_dual}, 32'h0);
        repeat (2) @(negedge clk);
        rd(3'd2, v); chk("R6 counter holds", v, 32'd0);
    endtask

    task automatic t_up_oneshot();
        logic [31:0] v;
        wr(3'd5, 32'hFFFF_FFFD);
        wr(3'd4, 32'h0000_00C0);      // run, ie, upward, no restart
        rd(3'd6, v); chk("R2 counter loaded ch1", v, 32'hFFFF_FFFD);
        @(negedge clk); rd(3'd6, v); chk("R4 increment", v, 32'hFFFF_FFFE);
        @(negedge clk); rd(3'd6, v); chk("R4 increment", v, 32'hFFFF_FFFF);
        rd(3'd4, v); chk("R4 no flag at all ones", v, 32'h0000_00C0);
        @(negedge clk);
        rd(3'd4, v); chk("R4 flag after count past all ones", v, 32'h0000_01C0);
        chk("R7 irq ch1", {31'b0, irq_dual}, 32'h1);
        repeat (2) @(negedge clk);
        rd(3'd6, v); chk("R6 up halt holds", v, 32'hFFFF_FFFF);
        wr(3'd4, 32'h0000_0040);
        rd(3'd4, v); chk("R8 zero write keeps flag", v, 32'h0000_0140);
        chk("R8 irq kept", {31'b0, irq_dual}, 32'h1);
        wr(3'd4, 32'h0000_0140);
        chk("R8 irq cleared", {31'b0, irq_dual}, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd4, 32'h0000_0080);      // run with ie off
        @(negedge clk);
        chk("R7 gated by enable", {31'b0, irq_dual}, 32'h0);
        wr(3'd4, 32'h0000_0040);
        chk("R7 enable opens gate", {31'b0, irq_dual}, 32'h1);
        wr(3'd6, 32'h0000_1234);
        rd(3'd6, v); chk("R11 counter write ignored", v, 32'hFFFF_FFFF);
        wr(3'd7, 32'h0000_0005);
        rd(3'd7, v); chk("R9 selector 3 reads zero", v, 32'h0);
        wr(3'd4, 32'h0000_0100);
        chk("R7 irq off after ack", {31'b0, irq_dual}, 32'h0);
    endtask

    task automatic t_ctrl_store();
        logic [31:0] v;
        wr(3'd4, 32'hFFFF_FE7F);
        rd(3'd4, v); chk("R10 stored control bits", v, 32'h0000_067F);
        chk("R10 no irq without flag", {31'b0, irq_dual}, 32'h0);
        wr(3'd4, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        wr(3'd5, 32'h0000_ABCD);
        wr(3'd4, 32'h0000_00C0);
        bus_addr = 3'd5; #1;
        chk("R9 absent channel reads zero", rdata_one, 32'h0);
        chk("R9 dual channel 1 load", rdata_dual, 32'h0000_ABCD);
        bus_addr = 3'd6; #1;
        chk("R9 absent counter reads zero", rdata_one, 32'h0);
        repeat (3) @(negedge clk);
        chk("R9 absent channel no irq", {31'b0, irq_one}, 32'h0);
        bus_addr = 3'd1; #1;
        chk("R9 present channel load", rdata_one, 32'd3);
        rd(3'd0, v);
    endtask

    initial begin
        #4_000_000;
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_down_restart();
        t_up_oneshot();
        t_ctrl_store();
        t_single();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule